// File: doc/BRIEF.md
# Separable Streaming Median Filter

This block removes impulse noise from a raster-scanned 8-bit greyscale image stream at a rate of one pixel per clock. The 3×3 median is split into two passes. The first pass takes the median of each three horizontally neighbouring pixels on a line. The second pass takes the median of three such horizontal results that sit in the same column on three successive lines. Each three-input median is built only from min/max comparators and 2:1 selections, with a register after every operator.

The line storage lives outside the block. The horizontal-median stream leaves on `hmed_o`, qualified by `hmed_valid_o`. The surrounding system delays this stream by one line and by two lines, and it returns both copies on `hmed_prev1_i` and `hmed_prev2_i` in the same cycle that `hmed_valid_o` is high. The block follows the raster position from a start-of-frame strobe. Results whose 3×3 window is not yet complete are marked as border results and are not marked valid.

Top module: `sep_median_filter`

## Requirements
- R1: Pixels are unsigned values of `DATA_W` bits (8 by default). For a pixel in column 2 or higher, `hmed_o` is the median of that pixel and the two valid pixels accepted before it.
- R2: For an interior pixel, `med_o` is the median of its `hmed_o` value and the `hmed_prev1_i` and `hmed_prev2_i` values sampled on the same rising edge as that `hmed_o`.
- R3: Latency is fixed. A pixel sampled on rising edge k drives `hmed_valid_o` high after edge k+3. Its final result drives `med_valid_o` or `border_o` high after edge k+6. In cycles with no sampled pixel these outputs stay low.
- R4: A new pixel may be accepted on every clock. Idle cycles (`pix_valid_i` low) leave the window and the position unchanged.
- R5: A result is a border result when its pixel is in column 0 or 1 of a line, or in row 0 or 1 of a frame. A border result raises `border_o` and keeps `med_valid_o` low.
- R6: A valid pixel sampled with `sof_i` high is taken as column 0, row 0, even when it arrives in the middle of a line. `sof_i` is ignored while `pix_valid_i` is low.
- R7: After `LINE_LEN` valid pixels the column count returns to 0 and the row count advances.
- R8: Every three-input median returns the correct value when two or all three of its inputs are equal.
- R9: While `rst_ni` is low, `hmed_valid_o`, `med_valid_o` and `border_o` are low.
- R10: `med_valid_o` and `border_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_valid_i | input | 1 | A pixel is present on `pix_i` |
| sof_i | input | 1 | The current valid pixel is the first pixel of a frame |
| pix_i | input | DATA_W | Grey level of the input pixel |
| hmed_prev1_i | input | DATA_W | Horizontal median at the same column, one line earlier |
| hmed_prev2_i | input | DATA_W | Horizontal median at the same column, two lines earlier |
| hmed_o | output | DATA_W | Horizontal median stream, sent to the external line delays |
| hmed_valid_o | output | 1 | `hmed_o` carries a result for an accepted pixel |
| med_o | output | DATA_W | Final 3×3 separable median |
| med_valid_o | output | 1 | `med_o` is an interior result |
| border_o | output | 1 | The result slot belongs to a border position |

## Verification
The bench aims at tied inputs. Frames are built so that pairs and triples of equal grey levels reach both median passes, and a min/max network with a wrong strictness or a swapped selection would return the odd value out. Frames also include the extremes 0 and 255, where a signed comparison would fail. The bench runs one frame with an idle cycle between every pixel: a window that shifted on idle cycles would mix stale pixels into the result, and a valid pipeline that was not tracked separately would move the results to the wrong cycle. It also restarts a frame partway through a line. A position tracker that ignored the restart, or that let line wrap mishandle the row count, would mark the wrong pixels as border.

// File: rtl/sepmed_pkg.sv
package sepmed_pkg;
  typedef struct packed {
    logic vld;
    logic brd;
  } tag_t;

  localparam int unsigned TAG_W = $bits(tag_t);
  localparam int unsigned MED3_LAT = 3;
endpackage

// File: rtl/pipe_delay.sv
module pipe_delay #(
  parameter int unsigned WIDTH = 2,
  parameter int unsigned DEPTH = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] sr_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) sr_q[i] <= '0;
    end else begin
      sr_q[0] <= d_i;
      for (int i = 1; i < DEPTH; i++) sr_q[i] <= sr_q[i-1];
    end
  end

  assign q_o = sr_q[DEPTH-1];
endmodule

// File: rtl/med3_pipe.sv
// median(a,b,c) = max(min(a,b), min(max(a,b), c)), one register per operator
module med3_pipe #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] c_i,
  output logic [DATA_W-1:0] med_o
);
  logic [DATA_W-1:0] lo_ab_q, hi_ab_q, c_q;
  logic [DATA_W-1:0] lo_ab_d2_q, lo_hc_q;
  logic [DATA_W-1:0] med_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_ab_q    <= '0;
      hi_ab_q    <= '0;
      c_q        <= '0;
      lo_ab_d2_q <= '0;
      lo_hc_q    <= '0;
      med_q      <= '0;
    end else begin
      // min / max stage
      lo_ab_q    <= (a_i < b_i) ? a_i : b_i;
      hi_ab_q    <= (a_i < b_i) ? b_i : a_i;
      c_q        <= c_i;
      // min stage
      lo_ab_d2_q <= lo_ab_q;
      lo_hc_q    <= (hi_ab_q < c_q) ? hi_ab_q : c_q;
      // final max selection
      med_q      <= (lo_ab_d2_q > lo_hc_q) ? lo_ab_d2_q : lo_hc_q;
    end
  end

  assign med_o = med_q;
endmodule

// File: rtl/raster_pos.sv
module raster_pos #(
  parameter int unsigned LINE_LEN = 512
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  input  logic sof_i,
  output logic brd_o
);
  localparam int unsigned COL_W = (LINE_LEN > 2) ? $clog2(LINE_LEN) : 2;
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(LINE_LEN - 1);

  logic [COL_W-1:0] col_q, col_cur;
  logic [1:0]       row_q, row_cur;   // saturates at 2
  logic             restart;

  assign restart = adv_i & sof_i;
  assign col_cur = restart ? '0 : col_q;
  assign row_cur = restart ? '0 : row_q;
  assign brd_o   = (col_cur < COL_W'(2)) || (row_cur < 2'd2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q <= '0;
      row_q <= '0;
    end else if (adv_i) begin
      if (col_cur == COL_LAST) begin
        col_q <= '0;
        row_q <= (row_cur == 2'd2) ? 2'd2 : row_cur + 2'd1;
      end else begin
        col_q <= col_cur + COL_W'(1);
        row_q <= row_cur;
      end
    end
  end
endmodule

// File: rtl/sep_median_filter.sv
module sep_median_filter
  import sepmed_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned LINE_LEN = 512
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pix_valid_i,
  input  logic              sof_i,
  input  logic [DATA_W-1:0] pix_i,
  input  logic [DATA_W-1:0] hmed_prev1_i,
  input  logic [DATA_W-1:0] hmed_prev2_i,
  output logic [DATA_W-1:0] hmed_o,
  output logic              hmed_valid_o,
  output logic [DATA_W-1:0] med_o,
  output logic              med_valid_o,
  output logic              border_o
);
  logic [DATA_W-1:0] tap1_q, tap2_q;
  logic [DATA_W-1:0] win_a_q, win_b_q, win_c_q;
  tag_t              win_tag_q, h_tag, v_tag;
  logic              pos_brd;

  raster_pos #(.LINE_LEN(LINE_LEN)) u_pos (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (pix_valid_i),
    .sof_i  (sof_i),
    .brd_o  (pos_brd)
  );

  // window capture: only accepted pixels shift the taps
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tap1_q    <= '0;
      tap2_q    <= '0;
      win_a_q   <= '0;
      win_b_q   <= '0;
      win_c_q   <= '0;
      win_tag_q <= '0;
    end else begin
      win_tag_q <= '{vld: pix_valid_i, brd: pos_brd};
      if (pix_valid_i) begin
        tap1_q  <= pix_i;
        tap2_q  <= tap1_q;
        win_a_q <= tap2_q;
        win_b_q <= tap1_q;
        win_c_q <= pix_i;
      end
    end
  end

  med3_pipe #(.DATA_W(DATA_W)) u_hmed (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .a_i    (win_a_q),
    .b_i    (win_b_q),
    .c_i    (win_c_q),
    .med_o  (hmed_o)
  );

  pipe_delay #(.WIDTH(TAG_W), .DEPTH(MED3_LAT)) u_htag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (win_tag_q),
    .q_o    (h_tag)
  );

  assign hmed_valid_o = h_tag.vld;

  med3_pipe #(.DATA_W(DATA_W)) u_vmed (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .a_i    (hmed_prev2_i),
    .b_i    (hmed_prev1_i),
    .c_i    (hmed_o),
    .med_o  (med_o)
  );

  pipe_delay #(.WIDTH(TAG_W), .DEPTH(MED3_LAT)) u_vtag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (h_tag),
    .q_o    (v_tag)
  );

  assign med_valid_o = v_tag.vld & ~v_tag.brd;
  assign border_o    = v_tag.vld &  v_tag.brd;
endmodule

// File: rtl/sep_median_chk.sv
module sep_median_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pix_valid_i,
  input logic              sof_i,
  input logic [DATA_W-1:0] hmed_prev1_i,
  input logic [DATA_W-1:0] hmed_prev2_i,
  input logic [DATA_W-1:0] hmed_o,
  input logic              hmed_valid_o,
  input logic [DATA_W-1:0] med_o,
  input logic              med_valid_o,
  input logic              border_o
);
  // R3
  h_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_i |-> ##4 hmed_valid_o);

  // R3
  h_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_valid_i |-> ##4 !hmed_valid_o);

  // R3
  v_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hmed_valid_o |-> ##3 (med_valid_o || border_o));

  // R10
  excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(med_valid_o && border_o));

  // R2
  pick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    med_valid_o |-> (med_o == $past(hmed_o, 3) || med_o == $past(hmed_prev1_i, 3)
                     || med_o == $past(hmed_prev2_i, 3)));

  // R6
  sof_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_i && sof_i) |-> ##7 border_o);
endmodule

bind sep_median_filter sep_median_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pix_valid_i  (pix_valid_i),
  .sof_i        (sof_i),
  .hmed_prev1_i (hmed_prev1_i),
  .hmed_prev2_i (hmed_prev2_i),
  .hmed_o       (hmed_o),
  .hmed_valid_o (hmed_valid_o),
  .med_o        (med_o),
  .med_valid_o  (med_valid_o),
  .border_o     (border_o)
);

// File: tb/sep_median_filter_bench.sv
module sep_median_filter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LINE = 6;
  localparam int ROWS = 5;
  localparam int REC  = 1024;

  localparam logic [7:0] FRAME_A [30] = '{
    8'd12,  8'd200, 8'd45,  8'd0,   8'd255, 8'd99,
    8'd13,  8'd13,  8'd250, 8'd7,   8'd128, 8'd64,
    8'd255, 8'd1,   8'd254, 8'd30,  8'd30,  8'd31,
    8'd100, 8'd90,  8'd110, 8'd0,   8'd0,   8'd200,
    8'd5,   8'd180, 8'd77,  8'd77,  8'd255, 8'd2
  };

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pix_valid_i = 1'b0;
  logic       sof_i = 1'b0;
  logic [7:0] pix_i = '0;
  logic [7:0] hmed_prev1_i = '0;
  logic [7:0] hmed_prev2_i = '0;
  logic [7:0] hmed_o, med_o;
  logic       hmed_valid_o, med_valid_o, border_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  sep_median_filter #(.DATA_W(8), .LINE_LEN(LINE)) u_sep_median_filter (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .pix_valid_i  (pix_valid_i),
    .sof_i        (sof_i),
    .pix_i        (pix_i),
    .hmed_prev1_i (hmed_prev1_i),
    .hmed_prev2_i (hmed_prev2_i),
    .hmed_o       (hmed_o),
    .hmed_valid_o (hmed_valid_o),
    .med_o        (med_o),
    .med_valid_o  (med_valid_o),
    .border_o     (border_o)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  // per-cycle records of the reference model
  bit         rv  [REC];
  bit         rb  [REC];
  int         rc  [REC];
  logic [7:0] rh  [REC];
  logic [7:0] rd1 [REC];
  logic [7:0] rd2 [REC];
  logic [7:0] rm  [REC];
  string      rt  [REC];

  logic [7:0] h1 [LINE];
  logic [7:0] h2 [LINE];
  logic [7:0] t1 = '0, t2 = '0;
  int mc = 0, mr = 0;

  function automatic logic [7:0] ref_med(input logic [7:0] a, b, c);
    if ((a >= b && a <= c) || (a <= b && a >= c)) return a;
    if ((b >= a && b <= c) || (b <= a && b >= c)) return b;
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step(input bit v, input logic [7:0] p, input bit s, input string tag);
    @(negedge clk);
    if (cyc >= 4) begin
      int i = (cyc - 4) % REC;
      check(hmed_valid_o == rv[i], "R3 hmed_valid", int'(hmed_valid_o), int'(rv[i]));
      if (rv[i] && rc[i] >= 2) check(hmed_o == rh[i], "R1 hmed", hmed_o, rh[i]);
      hmed_prev1_i = rd1[i];
      hmed_prev2_i = rd2[i];
    end
    if (cyc >= 7) begin
      int j = (cyc - 7) % REC;
      check(border_o == (rv[j] && rb[j]), "R5 border", int'(border_o), int'(rv[j] && rb[j]));
      check(med_valid_o == (rv[j] && !rb[j]), "R3 med_valid", int'(med_valid_o),
            int'(rv[j] && !rb[j]));
      check(!(med_valid_o && border_o), "R10 exclusive", int'(med_valid_o && border_o), 0);
      if (rv[j] && !rb[j]) check(med_o == rm[j], rt[j], med_o, rm[j]);
    end
    begin
      int k = cyc % REC;
      rv[k] = v;
      rb[k] = 1'b0;
      rc[k] = 0;
      rh[k] = '0;
      rd1[k] = '0;
      rd2[k] = '0;
      rm[k] = '0;
      rt[k] = tag;
      if (v) begin
        if (s) begin
          mc = 0;
          mr = 0;
        end
        rh[k]  = ref_med(t2, t1, p);
        t2 = t1;
        t1 = p;
        rd1[k] = h1[mc];
        rd2[k] = h2[mc];
        h2[mc] = h1[mc];
        h1[mc] = rh[k];
        rm[k]  = ref_med(rd2[k], rd1[k], rh[k]);
        rc[k]  = mc;
        rb[k]  = (mc < 2) || (mr < 2);
        if (mc == LINE - 1) begin
          mc = 0;
          mr++;
        end else begin
          mc++;
        end
      end
    end
    pix_valid_i = v;
    pix_i = p;
    sof_i = s;
    cyc++;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < LINE; i++) begin
      h1[i] = '0;
      h2[i] = '0;
    end
    // R9: outputs quiet in reset
    repeat (3) @(negedge clk);
    check(hmed_valid_o == 1'b0, "R9 hmed_valid", int'(hmed_valid_o), 0);
    check(med_valid_o == 1'b0, "R9 med_valid", int'(med_valid_o), 0);
    check(border_o == 1'b0, "R9 border", int'(border_o), 0);
    rst_ni = 1'b1;

    // table frame, back-to-back pixels, line wrap (R2, R4, R7)
    for (int n = 0; n < LINE * ROWS; n++)
      step(1'b1, FRAME_A[n], n == 0, "R2 med table");

    // ties: repeated values and a flat line (R8)
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < LINE; c++)
        step(1'b1, (r == 2) ? 8'd77 : (((c + r) % 3 == 0) ? 8'd90 : 8'd30),
             (r == 0 && c == 0), "R8 med ties");

    // idle cycle between every pixel; sof_i high on idle cycles is ignored (R4, R6)
    for (int n = 0; n < LINE * ROWS; n++) begin
      step(1'b1, FRAME_A[LINE * ROWS - 1 - n], n == 0, "R4 med gaps");
      step(1'b0, 8'hAA, 1'b1, "R4 idle");
    end

    // restart partway through a line (R6)
    for (int c = 0; c < 3; c++) step(1'b1, 8'd40 + 8'(c), 1'b0, "R6 partial");
    for (int n = 0; n < LINE * 3; n++)
      step(1'b1, 8'(n * 37 + 11), n == 0, "R6 med restart");

    for (int n = 0; n < 10; n++) step(1'b0, 8'h00, 1'b0, "flush");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule